// File: doc/BRIEF.md
# Wake Event Status Controller

The block gathers wake events from a set of general-purpose sources arranged in groups of eight. Each source input passes through a two-flop synchronizer, and a rising edge on the synchronized level is a wake event. Every event sets a sticky status bit for its source. The bit is set whatever the source's enable bit or the global enable holds. Each source also has an enable bit. A single shared, active-low wake request goes low while any source has both its status bit and its enable bit set and the global enable input is high.

Software reaches the status and enable bits through a byte-wide register port. Reads are combinational and writes take effect on the clock edge. A status bit clears only when a 1 is written to it. The registers sit in the standby-power domain: only the standby reset clears them. The combined main-power and software reset only blocks writes from the port. During that reset, events are still recorded.

Top module: `wake_status_ctrl`

## Requirements
- R1: A rising edge of source input n (bit b of group g is source 8g+b) sets its status bit. Detection goes through a two-flop synchronizer plus an edge flop. If the input is first sampled high at clock edge k, the bit reads 1 after edge k+2. This happens regardless of the source's enable bit and of `glob_en`.
- R2: Writing a byte to a status register clears every bit written as 1. Bits written as 0 keep their value.
- R3: `wake_n` is low exactly when `glob_en` is 1 and at least one source has both its status bit and its enable bit at 1. It follows register and `glob_en` changes combinationally, with no added cycle.
- R4: A source whose enable bit is 0 still records events in its status bit, but its status bit never pulls `wake_n` low.
- R5: While `stby_rst_n` is low, all status and enable bits are 0x00 and `wake_n` is 1. The reset is asynchronous.
- R6: While `main_rst_n` is low, port writes have no effect. Status and enable bits keep their values, and new events still set status bits.
- R7: Address map. Status group g is at 0x07+g and enable group g is at 0x0A+g, so the default two groups use 0x07, 0x08, 0x0A and 0x0B. Offset 0x09 is reserved: it reads 0 and ignores writes. Every other offset reads 0.
- R8: If an event and a write-1 clear of the same status bit meet at one clock edge, the bit stays 1.
- R9: A source held high sets its status bit once only. After that bit is cleared, it stays 0 until the next rising edge. A falling edge sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-domain reset, active low, asynchronous |
| main_rst_n | input | 1 | Combined main-power and software reset, active low; blocks port writes |
| src_i | input | 8*NUM_GROUPS | Asynchronous wake source levels |
| glob_en | input | 1 | Global wake enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wake_n | output | 1 | Shared wake request, active low |

## Verification
Assertions check several properties on every cycle. A pending event always appears in its status bit one edge later, which covers the case where a clear arrives at the same edge. A status bit never falls unless it was written with a 1. The global enable low always forces the wake output high. A held main reset freezes the enable bits and lets no status bit fall. The reserved offset always reads zero. The bench's reference model compares both outputs on every cycle. It also drives directed scenarios that only a sequence can show: the three-edge event latency, that a held level fires once only, the exact address decoding, and the recovery of the state after each kind of reset.

// File: rtl/wake_status_ctrl.sv
module wake_status_ctrl #(
  parameter int                NUM_GROUPS = 2,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE  = 'h07,
  parameter logic [ADDR_W-1:0] EN_BASE    = 'h0A
) (
  input  logic                    clk,
  input  logic                    stby_rst_n,
  input  logic                    main_rst_n,
  input  logic [8*NUM_GROUPS-1:0] src_i,
  input  logic                    glob_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    wake_n
);
  localparam int NSRC = 8 * NUM_GROUPS;
  localparam logic [ADDR_W-1:0] RSVD_ADDR = STAT_BASE + ADDR_W'(NUM_GROUPS);

  logic [NSRC-1:0] sync1, sync2, prev, ev;
  logic [NSRC-1:0] stat_q, en_q, clr, en_nxt;
  logic            wr_ok;

  assign wr_ok = wr_en & main_rst_n;
  assign ev    = sync2 & ~prev;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    wire stat_hit = (addr == STAT_BASE + ADDR_W'(g));
    wire en_hit   = (addr == EN_BASE + ADDR_W'(g));
    assign clr[8*g +: 8]    = (wr_ok && stat_hit) ? wdata : 8'h00;
    assign en_nxt[8*g +: 8] = (wr_ok && en_hit) ? wdata : en_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge stby_rst_n) begin
    if (!stby_rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      sync1  <= src_i;
      sync2  <= sync1;
      prev   <= sync2;
      stat_q <= (stat_q & ~clr) | ev;
      en_q   <= en_nxt;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (addr == STAT_BASE + ADDR_W'(g)) rdata = stat_q[8*g +: 8];
      if (addr == EN_BASE + ADDR_W'(g))   rdata = en_q[8*g +: 8];
    end
  end

  assign wake_n = ~(glob_en & (|(stat_q & en_q)));

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!stby_rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev))); // R1
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!stby_rst_n)
    ((ev & clr) != '0) |=> ((stat_q & $past(ev & clr)) == $past(ev & clr))); // R8
  AST_NO_UNCLEARED_FALL: assert property (@(posedge clk) disable iff (!stby_rst_n)
    (($past(stat_q) & ~$past(clr) & ~stat_q) == '0)); // R2
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !glob_en |-> wake_n); // R3
  AST_MAIN_RST_EN_HOLD: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !main_rst_n |=> $stable(en_q)); // R6
  AST_MAIN_RST_STAT_HOLD: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !main_rst_n |=> (($past(stat_q) & ~stat_q) == '0)); // R6
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!stby_rst_n)
    (addr == RSVD_ADDR) |-> (rdata == 8'h00)); // R7
endmodule

// File: tb/tb_wake_status_ctrl.sv
module tb_wake_status_ctrl;
  logic        clk = 0;
  logic        stby_rst_n = 0, main_rst_n = 0;
  logic [15:0] src_i = '0;
  logic        glob_en = 0, wr_en = 0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic [7:0]  rdata;
  logic        wake_n;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  wake_status_ctrl dut (
    .clk(clk), .stby_rst_n(stby_rst_n), .main_rst_n(main_rst_n), .src_i(src_i),
    .glob_en(glob_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wake_n(wake_n));

  // behavioural reference: history of sampled inputs, status and enable words
  logic [15:0] hist[$];
  logic [15:0] m_stat, m_en;

  always @(posedge clk or negedge stby_rst_n) begin
    if (!stby_rst_n) begin
      m_stat = '0; m_en = '0;
      hist = {16'h0, 16'h0, 16'h0};
    end else begin
      logic [15:0] evt, clear;
      evt = hist[1] & ~hist[2];
      clear = '0;
      if (wr_en && main_rst_n) begin
        if (addr == 8'h07) clear[7:0]  = wdata;
        if (addr == 8'h08) clear[15:8] = wdata;
        if (addr == 8'h0A) m_en[7:0]   = wdata;
        if (addr == 8'h0B) m_en[15:8]  = wdata;
      end
      m_stat = (m_stat & ~clear) | evt;
      hist.push_front(src_i);
      while (hist.size() > 4) void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h07: return m_stat[7:0];
      8'h08: return m_stat[15:8];
      8'h0A: return m_en[7:0];
      8'h0B: return m_en[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(rdata, m_read(addr), "R7 per-cycle rdata");
    check({7'b0, wake_n}, {7'b0, ~(glob_en & (|(m_stat & m_en)))}, "R3 per-cycle wake_n");
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1 addr = a;
    #1 check(rdata, exp, req);
  endtask

  task automatic pulse(input int n);
    @(posedge clk); #1 src_i[n] = 1;
    @(posedge clk); #1 src_i[n] = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic chk_wake(input logic exp, input string req);
    #1 check({7'b0, wake_n}, {7'b0, exp}, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rd(8'h07, 8'h00, "R5 reset status0");
    rd(8'h0B, 8'h00, "R5 reset enable1");
    chk_wake(1'b1, "R5 reset wake_n");
    #1 stby_rst_n = 1; main_rst_n = 1;

    pulse(3);
    rd(8'h07, 8'h08, "R1 event latched while disabled");
    chk_wake(1'b1, "R4 disabled source no wake");
    wr(8'h0A, 8'h08);
    #1 glob_en = 1;
    chk_wake(1'b0, "R3 wake asserted");
    #1 glob_en = 0;
    chk_wake(1'b1, "R3 global gate");
    #1 glob_en = 1;
    wr(8'h07, 8'hF7);
    rd(8'h07, 8'h08, "R2 write zero keeps bit");
    wr(8'h07, 8'h08);
    chk_wake(1'b1, "R3 wake released after clear");
    rd(8'h07, 8'h00, "R2 write one clears");

    pulse(9);
    rd(8'h08, 8'h02, "R7 group1 bit1");
    rd(8'h07, 8'h00, "R7 group0 untouched");
    wr(8'h0B, 8'h02);
    chk_wake(1'b0, "R3 group1 wake");
    wr(8'h09, 8'hFF);
    rd(8'h09, 8'h00, "R7 reserved reads zero");
    rd(8'h0A, 8'h08, "R7 reserved write ignored");
    rd(8'h0C, 8'h00, "R7 unmapped reads zero");
    rd(8'h3F, 8'h00, "R7 unmapped reads zero");
    wr(8'h08, 8'h02);

    @(posedge clk); #1 src_i[10] = 1;
    repeat (4) @(posedge clk);
    rd(8'h08, 8'h04, "R9 held level sets once");
    wr(8'h08, 8'h04);
    repeat (4) @(posedge clk);
    rd(8'h08, 8'h00, "R9 held level no re-set");
    #1 src_i[10] = 0;
    repeat (4) @(posedge clk);
    rd(8'h08, 8'h00, "R9 falling edge ignored");

    pulse(5);
    rd(8'h07, 8'h20, "R1 bit5 set");
    @(posedge clk); #1 src_i[5] = 1;
    @(posedge clk);
    @(posedge clk); #1 wr_en = 1; addr = 8'h07; wdata = 8'h20;
    @(posedge clk); #1 wr_en = 0;
    rd(8'h07, 8'h20, "R8 event beats clear");
    #1 src_i[5] = 0;
    wr(8'h07, 8'h20);
    rd(8'h07, 8'h00, "R2 clear after collision");

    #1 main_rst_n = 0;
    wr(8'h0A, 8'hFF);
    rd(8'h0A, 8'h08, "R6 enable write blocked");
    pulse(0);
    rd(8'h07, 8'h01, "R6 event recorded in main reset");
    wr(8'h07, 8'h01);
    rd(8'h07, 8'h01, "R6 clear blocked");
    #1 main_rst_n = 1;
    rd(8'h0A, 8'h08, "R6 enable retained");

    @(posedge clk); #1 stby_rst_n = 0;
    chk_wake(1'b1, "R5 wake_n in standby reset");
    @(posedge clk); #1 stby_rst_n = 1;
    rd(8'h07, 8'h00, "R5 status cleared");
    rd(8'h0A, 8'h00, "R5 enable cleared");
    rd(8'h0B, 8'h00, "R5 enable1 cleared");

    pulse(12);
    rd(8'h08, 8'h10, "R4 records with enable zero");
    chk_wake(1'b1, "R4 no wake with enable zero");

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule